// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble

This block is the transmit half of a microcontroller serial port. Software programs a 13-bit rate divisor and a control byte through a small register bus. It then sends characters by writing a data register. The block adds the start bit, the stop bit and, if selected, a parity bit, and shifts each frame out least significant bit first on a single line. When the line is idle it sits at logic 1.

Turning the transmitter on first sends a run of idle ones. Only after that does the first character leave the shift register. A two-step handshake guards the buffer-empty and frame-complete flags: software reads the status register while the flag is set, and then writes the low data byte. Either flag can raise an interrupt request. A break control fills frames with zeros.

Register map (bus_addr): 0 = divisor upper bits (bits 4:0 hold divisor bits 12:8), 1 = divisor low byte, 2 = control, 3 = status (read only), 4 = ninth-bit register (bit 0), 5 = low data byte. Control bits: 0 enable, 1 break, 2 nine-bit format, 3 parity on, 4 odd parity, 5 empty interrupt enable, 6 complete interrupt enable. Status bits: 7 buffer empty, 6 transmission complete, all others 0.

Top module: `sertx`

## Requirements
- R1: After reset, txd is 1, status reads 8'hC0 (empty and complete both set) and irq is 0.
- R2: A 0-to-1 change of the control enable bit first sends a preamble of ones lasting 10 bit times (8-bit format) or 11 bit times (nine-bit format). A character that is already waiting starts only after the preamble, between 1 and 16 clocks beyond that span when the divisor is 1.
- R3: An 8-bit frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit, for 10 bit times.
- R4: In nine-bit format the frame carries 9 data bits, the ninth taken from bit 0 of register 4, followed by the stop bit, for 11 bit times.
- R5: With parity on, the parity bit takes the place of the character's most significant bit (data bit 7 in 8-bit format, the ninth bit in nine-bit format). It is computed over the remaining data bits: even parity makes the count of ones even, odd parity makes it odd.
- R6: The empty flag sets when a character moves into the shift register. A character written during the previous frame follows that frame with no idle gap.
- R7: The empty and complete flags clear only when a status read sees the flag set and a later write to register 5 follows. A data write with no such read leaves the empty flag set and sends nothing.
- R8: The complete flag sets when a frame finishes and nothing is waiting to be sent, and the line then stays at 1.
- R9: One bit lasts 16 times the divisor in clocks. A divisor of 0 stops all transmission.
- R10: While break is set and the transmitter is enabled, whole frames of zeros are sent (10 or 11 bit times each). Clearing break returns the line to 1 at a frame boundary.
- R11: irq is 1 exactly when (empty and empty interrupt enable) or (complete and complete interrupt enable).
- R12: Clearing the enable bit lets the frame in progress finish. The line then stays at 1, and a waiting character is held until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Interrupt request |

## Verification
Every low-byte value is sent in plain 8-bit format, so a swapped, dropped or misordered data bit shows up in at least one frame. Further sweeps in even-parity, odd-parity and nine-bit formats, with the ninth bit toggling, check which bit parity replaces and its polarity. Frames sent back to back must start exactly one frame length apart, which exposes idle gaps and wrong bit periods. Separate sequences cover the following, each of which separates a correct flag or timing path from a near miss:
- the delay from an enable edge to the first frame in both formats
- a data write without the status read
- a disable in the middle of a frame
- break lengths
- a divisor of 3 and of 0

// File: rtl/sertx.sv
module sertx #(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  output logic       irq
);
  localparam int HI_W = DIV_W - 8;
  localparam int OW   = $clog2(OVS);
  localparam int FW   = 11;
  localparam logic [2:0] A_DIVH = 3'd0, A_DIVL = 3'd1, A_CTRL = 3'd2,
                         A_STAT = 3'd3, A_DHI  = 3'd4, A_DLO  = 3'd5;

  logic [DIV_W-1:0] div_q, pcnt;
  logic [OW-1:0]    ocnt;
  logic [7:0]       ctrl_q, dlo_q;
  logic             t8_q, flag_e, flag_d, arm_e, arm_d, pre_pend;
  logic [FW-1:0]    shreg, frame;
  logic [3:0]       bcnt;

  wire ten  = ctrl_q[0];
  wire brk  = ctrl_q[1];
  wire m9   = ctrl_q[2];
  wire pen  = ctrl_q[3];
  wire podd = ctrl_q[4];
  wire ie_e = ctrl_q[5];
  wire ie_d = ctrl_q[6];

  wire wr_any  = bus_sel && bus_wr;
  wire wr_ctrl = wr_any && bus_addr == A_CTRL;
  wire wr_dlo  = wr_any && bus_addr == A_DLO;
  wire rd_stat = bus_sel && !bus_wr && bus_addr == A_STAT;
  wire ten_rise = wr_ctrl && bus_wdata[0] && !ten;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dlo_q  <= '0;
      t8_q   <= 1'b0;
    end else if (wr_any) begin
      case (bus_addr)
        A_DIVH:  div_q[DIV_W-1:8] <= bus_wdata[HI_W-1:0];
        A_DIVL:  div_q[7:0] <= bus_wdata;
        A_CTRL:  ctrl_q <= bus_wdata;
        A_DHI:   t8_q <= bus_wdata[0];
        A_DLO:   dlo_q <= bus_wdata;
        default: ;
      endcase
    end

  always_comb
    case (bus_addr)
      A_DIVH:  bus_rdata = {{(8-HI_W){1'b0}}, div_q[DIV_W-1:8]};
      A_DIVL:  bus_rdata = div_q[7:0];
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {flag_e, flag_d, 6'b0};
      A_DHI:   bus_rdata = {7'b0, t8_q};
      A_DLO:   bus_rdata = dlo_q;
      default: bus_rdata = 8'h00;
    endcase

  wire div_on = div_q != '0;
  wire btick  = div_on && pcnt == div_q - 1'b1;
  wire bit_tick = btick && ocnt == OW'(OVS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0;
      ocnt <= '0;
    end else if (!div_on) begin
      pcnt <= '0;
    end else if (btick) begin
      pcnt <= '0;
      ocnt <= (ocnt == OW'(OVS - 1)) ? '0 : ocnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end

  wire [3:0] flen = m9 ? 4'd11 : 4'd10;
  wire slot    = bit_tick && bcnt <= 4'd1;
  wire ld_pre  = slot && ten && pre_pend;
  wire ld_brk  = slot && ten && !pre_pend && brk;
  wire ld_data = slot && ten && !pre_pend && !brk && !flag_e;
  wire go_idle = slot && !(ld_pre || ld_brk || ld_data);
  wire pbit    = (m9 ? ^dlo_q : ^dlo_q[6:0]) ^ podd;

  always_comb
    if (m9) frame = {1'b1, pen ? pbit : t8_q, dlo_q, 1'b0};
    else    frame = {2'b11, pen ? pbit : dlo_q[7], dlo_q[6:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '1;
      bcnt  <= '0;
    end else if (ld_pre) begin
      shreg <= '1;
      bcnt  <= flen;
    end else if (ld_brk) begin
      shreg <= '0;
      bcnt  <= flen;
    end else if (ld_data) begin
      shreg <= frame;
      bcnt  <= flen;
    end else if (go_idle) begin
      shreg <= '1;
      bcnt  <= '0;
    end else if (bit_tick && bcnt > 4'd1) begin
      shreg <= {1'b1, shreg[FW-1:1]};
      bcnt  <= bcnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre_pend <= 1'b0;
    else if (ten_rise)         pre_pend <= 1'b1;
    else if (ld_pre || !ten)   pre_pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_e <= 1'b1;
      flag_d <= 1'b1;
      arm_e  <= 1'b0;
      arm_d  <= 1'b0;
    end else begin
      if (ld_data)              flag_e <= 1'b1;
      else if (wr_dlo && arm_e) flag_e <= 1'b0;
      if (go_idle && bcnt == 4'd1) flag_d <= 1'b1;
      else if (wr_dlo && arm_d)    flag_d <= 1'b0;
      if (wr_dlo)                arm_e <= 1'b0;
      else if (rd_stat && flag_e) arm_e <= 1'b1;
      if (wr_dlo)                arm_d <= 1'b0;
      else if (rd_stat && flag_d) arm_d <= 1'b1;
    end

  assign txd = (bcnt == 4'd0) || shreg[0];
  assign irq = (flag_e && ie_e) || (flag_d && ie_d);

  AST_START_LOW:  assert property (@(posedge clk) disable iff (!rst_n) ld_data |=> !txd);                  // R3
  AST_EMPTY_SET:  assert property (@(posedge clk) disable iff (!rst_n) ld_data |=> flag_e);                // R6
  AST_NO_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_dlo && !arm_e && flag_e && !ld_data) |=> flag_e);                                 // R7
  AST_ZERO_DIV:   assert property (@(posedge clk) disable iff (!rst_n) !div_on |-> !bit_tick);            // R9
  AST_BRK_LOW:    assert property (@(posedge clk) disable iff (!rst_n) ld_brk |=> !txd);                  // R10
  AST_HOLD_LINE:  assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(txd));        // R9
  AST_OFF_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (!ten && bcnt == 4'd0) |=> txd);   // R12
  AST_CNT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) bcnt <= 4'd11);                     // R4
endmodule

// File: tb/sertx_bench.sv
`timescale 1ns/1ps
module sertx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic txd, irq;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  sertx u_sertx (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .txd, .irq);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic send(input logic [7:0] d);
    logic [7:0] s;
    s = 0;
    while (!s[7]) bus_read(3'd3, s);
    bus_write(3'd5, d);
  endtask

  task automatic rx_frame(input int per, input int nb, output logic [10:0] bits, output int t);
    bit ok;
    ok = 0; bits = '1; t = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!txd) begin t = cyc; ok = 1; break; end
    end
    if (!ok) begin
      chk("R3 start bit timeout", 0, 1);
      return;
    end
    repeat (per / 2) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < nb; k++) begin
      repeat (per) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  function automatic logic [10:0] efr(bit m9, bit pen, bit podd, bit t8, logic [7:0] d);
    int nd, ones;
    logic [8:0] ch;
    logic [10:0] f;
    nd = m9 ? 9 : 8;
    ch = {t8, d};
    if (pen) begin
      ones = 0;
      for (int k = 0; k < nd - 1; k++) ones += ch[k];
      ch[nd-1] = (ones % 2 == 1) ^ podd;
    end
    f = '1;
    f[0] = 1'b0;
    for (int k = 0; k < nd; k++) f[k+1] = ch[k];
    f[nd+1] = 1'b1;
    return f;
  endfunction

  task automatic quiet(input int n, input string req);
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk(req, lows, 0);
  endtask

  task automatic sweep(input bit m9, input bit pen, input bit podd, input int n,
                       input int step, input int off, input string req);
    logic [10:0] bits, mask;
    int t, tp, nb;
    logic [7:0] d;
    bit t8;
    nb = m9 ? 11 : 10;
    mask = 11'((1 << nb) - 1);
    tp = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'((i * step + off) & 255);
      t8 = (i >> 1) & 1;
      if (m9) bus_write(3'd4, {7'b0, t8});
      send(d);
      rx_frame(16, nb, bits, t);
      chk(req, bits & mask, efr(m9, pen, podd, t8, d) & mask);
      if (i > 0) chk("R6 back-to-back spacing", t - tp, 16 * nb);
      tp = t;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [10:0] bits;
    int t, t_en, t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 irq", irq, 0);
    bus_read(3'd3, s);
    chk("R1 status", s, 8'hC0);

    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h01);
    bus_write(3'd2, 8'h01);
    t_en = cyc;
    send(8'h55);
    rx_frame(16, 10, bits, t);
    chk_rng("R2 preamble 8-bit", t - t_en, 161, 176);
    chk("R3 first frame", bits[9:0], efr(0, 0, 0, 0, 8'h55) & 11'h3FF);

    sweep(0, 0, 0, 256, 1, 0, "R3 8-bit sweep");
    bus_write(3'd2, 8'h09);
    sweep(0, 1, 0, 64, 3, 1, "R5 even parity");
    bus_write(3'd2, 8'h19);
    sweep(0, 1, 1, 64, 5, 2, "R5 odd parity");

    bus_write(3'd2, 8'h04);
    repeat (40) @(negedge clk);
    bus_write(3'd2, 8'h05);
    t_en = cyc;
    bus_write(3'd4, 8'h01);
    send(8'hC3);
    rx_frame(16, 11, bits, t);
    chk_rng("R2 preamble 9-bit", t - t_en, 177, 192);
    chk("R4 first 9-bit frame", bits, efr(1, 0, 0, 1, 8'hC3));
    sweep(1, 0, 0, 64, 7, 3, "R4 9-bit sweep");
    bus_write(3'd2, 8'h1D);
    sweep(1, 1, 1, 32, 11, 4, "R5 9-bit odd parity");

    bus_write(3'd2, 8'h01);
    repeat (40) @(negedge clk);
    bus_write(3'd5, 8'h11);
    quiet(400, "R7 unarmed write sends nothing");
    bus_read(3'd3, s);
    chk("R7 empty stays set", s[7], 1);
    chk("R8 complete after idle", s[6], 1);
    bus_write(3'd5, 8'h22);
    bus_read(3'd3, s);
    chk("R7 armed write clears flags", s[7:6], 2'b00);
    rx_frame(16, 10, bits, t);
    chk("R7 frame after armed write", bits[9:0], efr(0, 0, 0, 0, 8'h22) & 11'h3FF);
    repeat (20) @(negedge clk);
    bus_read(3'd3, s);
    chk("R8 complete set after frame", s[6], 1);
    chk("R8 line idle", txd, 1);

    bus_write(3'd2, 8'h21);
    chk("R11 irq empty", irq, 1);
    bus_write(3'd2, 8'h41);
    chk("R11 irq complete", irq, 1);
    bus_write(3'd2, 8'h21);
    bus_read(3'd3, s);
    bus_write(3'd5, 8'h9A);
    chk("R11 irq low while pending", irq, 0);
    rx_frame(16, 10, bits, t);
    chk("R11 irq after load", irq, 1);
    chk("R3 frame 9A", bits[9:0], efr(0, 0, 0, 0, 8'h9A) & 11'h3FF);
    bus_write(3'd2, 8'h01);
    chk("R11 irq disabled", irq, 0);

    repeat (40) @(negedge clk);
    send(8'h3C);
    fork
      rx_frame(16, 10, bits, t);
      begin repeat (60) @(negedge clk); bus_write(3'd2, 8'h00); end
    join
    chk("R12 frame finishes", bits[9:0], efr(0, 0, 0, 0, 8'h3C) & 11'h3FF);
    send(8'h81);
    quiet(400, "R12 idle while disabled");
    bus_read(3'd3, s);
    chk("R12 data held pending", s[7], 0);
    bus_write(3'd2, 8'h01);
    t_en = cyc;
    rx_frame(16, 10, bits, t);
    chk_rng("R2 preamble before held data", t - t_en, 161, 176);
    chk("R12 held data sent", bits[9:0], efr(0, 0, 0, 0, 8'h81) & 11'h3FF);

    repeat (40) @(negedge clk);
    bus_write(3'd2, 8'h03);
    rx_frame(16, 1, bits, t0);
    repeat (400) @(negedge clk);
    bus_write(3'd2, 8'h01);
    t1 = t0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (txd) begin t1 = cyc; break; end
    end
    chk("R10 break 10-bit multiple", (t1 - t0) % 160, 0);
    chk_rng("R10 break length", t1 - t0, 480, 800);
    repeat (40) @(negedge clk);
    bus_write(3'd2, 8'h07);
    rx_frame(16, 1, bits, t0);
    repeat (300) @(negedge clk);
    bus_write(3'd2, 8'h05);
    t1 = t0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (txd) begin t1 = cyc; break; end
    end
    chk("R10 break 11-bit multiple", (t1 - t0) % 176, 0);

    bus_write(3'd2, 8'h01);
    repeat (40) @(negedge clk);
    bus_write(3'd1, 8'h03);
    send(8'hA5);
    rx_frame(48, 10, bits, t);
    chk("R9 divisor 3 frame", bits[9:0], efr(0, 0, 0, 0, 8'hA5) & 11'h3FF);
    bus_write(3'd1, 8'h00);
    send(8'h0F);
    quiet(1000, "R9 zero divisor stops");
    bus_read(3'd3, s);
    chk("R9 zero divisor no load", s[7], 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule